// File: doc/BRIEF.md
# Clock-Ratio-Aware Extension Issue Interlock

This block decides, on every cycle of a fast processor pipeline, whether an extension instruction may be sent to a slower execution fabric. The fabric is clocked from the same source through a clock enable that is high on one processor cycle in every N cycles. N is 1, 2, 3 or 4 and comes from a programmable ratio setting. The 32-entry, 128-bit wide register file is the only place where data passes between the two rates. The interlock therefore tracks, for each wide register, how many fabric cycles remain before a pending result can be read.

A 16-entry timing table is indexed by the extension opcode. Each entry holds the instruction's latency in fabric cycles and the fabric stage, counted from issue, at which it reads its sources. An instruction issues only on a cycle where the fabric enable is high and neither a read-after-write nor a write-after-write conflict exists. The spacing between dependent issues therefore follows from both the clock ratio and the table timing. A new ratio is taken only while no result is outstanding.

Top module: `ext_issue_ilk`

## Requirements
- R1: After reset the ratio code reads 0, fab_ce is high, busy is low, and every table entry holds latency 1 with read stage 0.
- R2: Ratio code k (0..3) makes fab_ce high on exactly one processor cycle in every k+1. The first high cycle is the cycle right after the write is accepted.
- R3: issue is high in the same cycle as req_valid only when fab_ce is high and no hazard exists. At most one issue happens per fabric cycle.
- R4: An instruction with latency L issued in fabric cycle t makes its destination readable by a reader with read stage s issued in fabric cycle t' only when t'+s >= t+L. Until then the reader stalls.
- R5: A write with latency L stalls while an earlier write to the same register still has L or more fabric cycles left, so writes complete in order. No check applies when req_dst_en is 0.
- R6: A table write stores a 4-bit latency and a 2-bit read stage for the addressed opcode. A latency of 0 is stored as 1. The new entry governs requests from the next cycle on.
- R7: A ratio write is accepted only in a cycle where busy is low and issue is low. Otherwise it is dropped and ratio_cur keeps its value.
- R8: busy is high exactly while some register has a pending write with at least one fabric cycle left.
- R9: Independent requests at ratio 1:1 issue back to back on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ratio_wr | input | 1 | Request to load a new clock ratio |
| ratio_code | input | 2 | Ratio to load: divisor minus one |
| ratio_cur | output | 2 | Ratio code in force |
| fab_ce | output | 1 | Fabric clock enable |
| tbl_wr | input | 1 | Timing-table write strobe |
| tbl_op | input | 4 | Opcode whose entry is written |
| tbl_lat | input | 4 | Latency in fabric cycles (0 stored as 1) |
| tbl_stage | input | 2 | Fabric stage at which sources are read |
| req_valid | input | 1 | An extension instruction asks to issue |
| req_op | input | 4 | Its opcode |
| req_src_a | input | 5 | First wide source register |
| req_src_b | input | 5 | Second wide source register |
| req_dst | input | 5 | Wide destination register |
| req_dst_en | input | 1 | The instruction writes req_dst |
| issue | output | 1 | The request issues this cycle |
| busy | output | 1 | Some wide register has a pending write |

## Verification
The assertions assume that a request holds its opcode and register fields steady from the cycle it is raised until it issues. They also assume the table entry of an opcode is not rewritten while a request for that opcode waits. The stimulus meets both: requests are raised just after a clock edge, held until the cycle in which issue is seen, and all table writes happen before any request uses them. Ratio writes are sent both while results are outstanding and while idle, and once in the same cycle as an issue, so the acceptance rule is exercised on both sides.

// File: rtl/ilk_pkg.sv
// Package: default sizes shared by the issue-interlock modules.
// Assumes a 2-bit ratio code (divisors 1..4) and a latency field wide
// enough to hold 15 fabric cycles.
package ilk_pkg;
    localparam int NREG_D = 32;   // wide registers tracked
    localparam int NOP_D  = 16;   // extension opcodes per configuration
    localparam int LATW_D = 4;    // latency field width
    localparam int STGW_D = 2;    // read-stage field width
    localparam int RATW_D = 2;    // ratio code width

    typedef enum logic [RATW_D-1:0] {
        DIV_BY_1 = 2'd0,
        DIV_BY_2 = 2'd1,
        DIV_BY_3 = 2'd2,
        DIV_BY_4 = 2'd3
    } ratio_e;
endpackage

// File: rtl/ilk_fab_enable.sv
// Module: ilk_fab_enable
// Holds the ratio code and produces the fabric clock enable: high on one
// processor cycle out of (code+1). Loading a code restarts the phase so
// that the next cycle is an enable cycle.
// Assumes the caller only loads when loading is permitted.
module ilk_fab_enable #(
    parameter int RATW = ilk_pkg::RATW_D
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [RATW-1:0] load_code,
    output logic [RATW-1:0] code_q,
    output logic            ce
);
    logic [RATW-1:0] phase_q;

    // Purpose: ratio register and phase counter that wraps at the code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= RATW'(ilk_pkg::DIV_BY_1);
            phase_q <= '0;
        end else if (load) begin
            code_q  <= load_code;
            phase_q <= '0;
        end else if (phase_q == code_q) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Purpose: the enable marks phase zero.
    always_comb ce = (phase_q == '0);

    // R2: with a divisor above one, an enable cycle is followed by a quiet one.
    a_r2_ce_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && code_q != '0 && !load) |=> !ce);
    // R2: the cycle after a load is an enable cycle.
    a_r2_ce_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ce);
endmodule

// File: rtl/ilk_op_timing.sv
// Module: ilk_op_timing
// Per-opcode timing table: latency in fabric cycles and the fabric stage
// at which sources are read. Written one entry per cycle; read
// combinationally by opcode. A zero latency is stored as one.
// Assumes LATW >= 1 and NOP is a power of two.
module ilk_op_timing #(
    parameter int NOP  = ilk_pkg::NOP_D,
    parameter int LATW = ilk_pkg::LATW_D,
    parameter int STGW = ilk_pkg::STGW_D,
    localparam int OPW = $clog2(NOP)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [OPW-1:0]  wr_op,
    input  logic [LATW-1:0] wr_lat,
    input  logic [STGW-1:0] wr_stage,
    input  logic [OPW-1:0]  rd_op,
    output logic [LATW-1:0] rd_lat,
    output logic [STGW-1:0] rd_stage
);
    logic [LATW-1:0] lat_q   [NOP];
    logic [STGW-1:0] stage_q [NOP];

    genvar g;
    generate
        for (g = 0; g < NOP; g++) begin : g_entry
            // Purpose: one table entry, reset to latency 1 / stage 0.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lat_q[g]   <= LATW'(1);
                    stage_q[g] <= '0;
                end else if (wr_en && wr_op == OPW'(g)) begin
                    lat_q[g]   <= (wr_lat == '0) ? LATW'(1) : wr_lat;
                    stage_q[g] <= wr_stage;
                end
            end
        end
    endgenerate

    // Purpose: combinational lookup for the requesting opcode.
    always_comb begin
        rd_lat   = lat_q[rd_op];
        rd_stage = stage_q[rd_op];
    end

    // R6: no entry ever reports a zero latency.
    a_r6_lat_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lat != '0);
endmodule

// File: rtl/ilk_wreg_track.sv
// Module: ilk_wreg_track
// Scoreboard over the wide registers. Each register keeps the number of
// fabric cycles left before its pending result may be read. An issue that
// writes a register loads latency-1; every fabric enable counts down.
// Reports read-after-write and write-after-write conflicts for a request.
// Assumes set_en is only raised on a fabric-enable cycle and STGW <= LATW.
module ilk_wreg_track #(
    parameter int NREG = ilk_pkg::NREG_D,
    parameter int LATW = ilk_pkg::LATW_D,
    parameter int STGW = ilk_pkg::STGW_D,
    localparam int REGW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ce,
    input  logic            set_en,
    input  logic [REGW-1:0] set_reg,
    input  logic [LATW-1:0] set_lat,
    input  logic [REGW-1:0] src_a,
    input  logic [REGW-1:0] src_b,
    input  logic [STGW-1:0] rd_stage,
    input  logic [REGW-1:0] dst,
    input  logic            dst_en,
    input  logic [LATW-1:0] new_lat,
    output logic            raw_hazard,
    output logic            waw_hazard,
    output logic            any_pending
);
    logic [LATW-1:0] left_q [NREG];
    logic [NREG-1:0] pend;
    logic [LATW-1:0] stage_ext;

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_reg
            // Purpose: remaining-cycle counter of one wide register.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    left_q[g] <= '0;
                end else if (set_en && set_reg == REGW'(g)) begin
                    left_q[g] <= set_lat - 1'b1;
                end else if (ce && left_q[g] != '0) begin
                    left_q[g] <= left_q[g] - 1'b1;
                end
            end

            // Purpose: pending flag of one register.
            always_comb pend[g] = (left_q[g] != '0);

            // R4: a pending count drops by one on each fabric cycle.
            a_r4_countdown: assert property (@(posedge clk) disable iff (!rst_n)
                (ce && !(set_en && set_reg == REGW'(g)) && left_q[g] != '0)
                |=> left_q[g] == $past(left_q[g]) - 1'b1);
            // R4: between fabric cycles nothing moves unless a write is issued.
            a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (!ce && !(set_en && set_reg == REGW'(g)))
                |=> $stable(left_q[g]));
        end
    endgenerate

    // Purpose: read stage widened to the counter width for comparison.
    always_comb stage_ext = LATW'(rd_stage);

    // Purpose: conflict detection for the current request.
    always_comb begin
        raw_hazard  = (left_q[src_a] > stage_ext) || (left_q[src_b] > stage_ext);
        waw_hazard  = dst_en && (left_q[dst] >= new_lat);
        any_pending = |pend;
    end
endmodule

// File: rtl/ext_issue_ilk.sv
// Module: ext_issue_ilk (top)
// Issue control for extension instructions crossing into a slower,
// isochronously enabled fabric. Combines the fabric enable, the opcode
// timing table and the wide-register scoreboard into a single issue
// decision per processor cycle, and gates ratio changes on idleness.
// Assumes request fields are held steady while req_valid waits.
module ext_issue_ilk #(
    parameter int NREG = ilk_pkg::NREG_D,
    parameter int NOP  = ilk_pkg::NOP_D,
    parameter int LATW = ilk_pkg::LATW_D,
    parameter int STGW = ilk_pkg::STGW_D,
    parameter int RATW = ilk_pkg::RATW_D,
    localparam int REGW = $clog2(NREG),
    localparam int OPW  = $clog2(NOP)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ratio_wr,
    input  logic [RATW-1:0] ratio_code,
    output logic [RATW-1:0] ratio_cur,
    output logic            fab_ce,
    input  logic            tbl_wr,
    input  logic [OPW-1:0]  tbl_op,
    input  logic [LATW-1:0] tbl_lat,
    input  logic [STGW-1:0] tbl_stage,
    input  logic            req_valid,
    input  logic [OPW-1:0]  req_op,
    input  logic [REGW-1:0] req_src_a,
    input  logic [REGW-1:0] req_src_b,
    input  logic [REGW-1:0] req_dst,
    input  logic            req_dst_en,
    output logic            issue,
    output logic            busy
);
    logic            ratio_load;
    logic [LATW-1:0] op_lat;
    logic [STGW-1:0] op_stage;
    logic            raw_hz;
    logic            waw_hz;

    ilk_fab_enable #(.RATW(RATW)) u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ratio_load),
        .load_code (ratio_code),
        .code_q    (ratio_cur),
        .ce        (fab_ce)
    );

    ilk_op_timing #(.NOP(NOP), .LATW(LATW), .STGW(STGW)) u_tab (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr),
        .wr_op    (tbl_op),
        .wr_lat   (tbl_lat),
        .wr_stage (tbl_stage),
        .rd_op    (req_op),
        .rd_lat   (op_lat),
        .rd_stage (op_stage)
    );

    ilk_wreg_track #(.NREG(NREG), .LATW(LATW), .STGW(STGW)) u_sb (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce          (fab_ce),
        .set_en      (issue && req_dst_en),
        .set_reg     (req_dst),
        .set_lat     (op_lat),
        .src_a       (req_src_a),
        .src_b       (req_src_b),
        .rd_stage    (op_stage),
        .dst         (req_dst),
        .dst_en      (req_dst_en),
        .new_lat     (op_lat),
        .raw_hazard  (raw_hz),
        .waw_hazard  (waw_hz),
        .any_pending (busy)
    );

    // Purpose: issue only on a fabric-enable cycle with no conflict.
    always_comb issue = req_valid && fab_ce && !raw_hz && !waw_hz;

    // Purpose: take a new ratio only when nothing is outstanding or starting.
    always_comb ratio_load = ratio_wr && !busy && !issue;

    // R3: with a divisor above one, two issues never fall on adjacent cycles.
    a_r3_one_per_fab_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && ratio_cur != '0) |=> !issue);
    // R7: the ratio holds across any cycle with work outstanding or issuing.
    a_r7_ratio_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || issue) |=> $stable(ratio_cur));
    // R8: a write with latency above one leaves the scoreboard busy.
    a_r8_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && req_dst_en && op_lat > LATW'(1)) |=> busy);
endmodule

// File: tb/sim_ext_issue_ilk.sv
// Bench for ext_issue_ilk: a driver task queues the expected issue cycle of
// each request; a monitor pops and compares when issue is seen.
module sim_ext_issue_ilk;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ratio_wr = 1'b0;
    logic [1:0] ratio_code = '0;
    logic [1:0] ratio_cur;
    logic       fab_ce;
    logic       tbl_wr = 1'b0;
    logic [3:0] tbl_op = '0;
    logic [3:0] tbl_lat = '0;
    logic [1:0] tbl_stage = '0;
    logic       req_valid = 1'b0;
    logic [3:0] req_op = '0;
    logic [4:0] req_src_a = '0;
    logic [4:0] req_src_b = '0;
    logic [4:0] req_dst = '0;
    logic       req_dst_en = 1'b0;
    logic       issue;
    logic       busy;

    int    cyc = 0;
    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    int    exp_cyc[$];
    string exp_tag[$];

    ext_issue_ilk u0 (
        .clk(clk), .rst_n(rst_n),
        .ratio_wr(ratio_wr), .ratio_code(ratio_code), .ratio_cur(ratio_cur),
        .fab_ce(fab_ce),
        .tbl_wr(tbl_wr), .tbl_op(tbl_op), .tbl_lat(tbl_lat), .tbl_stage(tbl_stage),
        .req_valid(req_valid), .req_op(req_op), .req_src_a(req_src_a),
        .req_src_b(req_src_b), .req_dst(req_dst), .req_dst_en(req_dst_en),
        .issue(issue), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: each observed issue must match the oldest queued expectation.
    always @(negedge clk) begin
        int    e;
        string t;
        if (rst_n && issue) begin
            if (exp_cyc.size() == 0) begin
                chk(1'b0, "R3 unexpected issue", cyc, -1);
            end else begin
                e = exp_cyc.pop_front();
                t = exp_tag.pop_front();
                chk(cyc == e, t, cyc, e);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wtab(input int op, input int lat, input int stg);
        tbl_wr = 1'b1; tbl_op = op[3:0]; tbl_lat = lat[3:0]; tbl_stage = stg[1:0];
        step(1);
        tbl_wr = 1'b0;
    endtask

    task automatic set_ratio(input int code);
        ratio_wr = 1'b1; ratio_code = code[1:0];
        step(1);
        ratio_wr = 1'b0;
    endtask

    // Driver: raise a request now, queue its expected issue cycle, hold it
    // until it issues, then drop it just after the next edge.
    task automatic do_issue(input int op, input int a, input int b, input int d,
                            input bit den, input int wt, input string tag);
        int guard;
        req_valid = 1'b1; req_op = op[3:0]; req_src_a = a[4:0];
        req_src_b = b[4:0]; req_dst = d[4:0]; req_dst_en = den;
        exp_cyc.push_back(cyc + wt);
        exp_tag.push_back(tag);
        guard = 0;
        forever begin
            @(negedge clk);
            if (issue) break;
            guard++;
            if (guard > 100) begin
                chk(1'b0, {tag, " never issued"}, guard, wt);
                break;
            end
        end
        step(1);
        req_valid = 1'b0;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(ratio_cur == 2'd0, "R1 ratio after reset", ratio_cur, 0);
        chk(fab_ce == 1'b1, "R1 fab_ce after reset", fab_ce, 1);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(issue == 1'b0, "R1 no issue without request", issue, 0);

        // R6: program timings (op4 gets latency 0, must behave as 1)
        wtab(1, 4, 0);
        wtab(2, 1, 0);
        wtab(3, 4, 2);
        wtab(4, 0, 0);
        wtab(5, 2, 0);

        // R9: independent back-to-back issues at 1:1; latency 1 needs no wait
        do_issue(2, 1, 2, 20, 1'b1, 0, "R9 first");
        do_issue(2, 20, 1, 21, 1'b1, 0, "R9 reader of latency-1 result");
        do_issue(2, 3, 4, 22, 1'b1, 0, "R9 third");

        // R4: latency 4, stage 0 reader waits 3 cycles at 1:1
        do_issue(1, 1, 2, 5, 1'b1, 0, "R4 producer lat4");
        chk(busy == 1'b1, "R8 busy while result pending", busy, 1);
        do_issue(2, 5, 1, 0, 1'b0, 3, "R4 stage0 reader");
        chk(busy == 1'b0, "R8 busy clears when drained", busy, 0);

        // R4: reader with read stage 2 waits only 1 cycle
        do_issue(3, 1, 2, 6, 1'b1, 0, "R4 producer stage2 case");
        do_issue(3, 6, 1, 0, 1'b0, 1, "R4 stage2 reader");
        step(3);

        // R5: latency-2 write behind latency-4 write to same register
        do_issue(1, 1, 2, 8, 1'b1, 0, "R5 older write");
        do_issue(5, 1, 2, 8, 1'b1, 2, "R5 younger write ordered");
        step(3);

        // R6: zero latency stored as one; R1: untouched op15 has latency 1
        do_issue(4, 1, 2, 11, 1'b1, 0, "R6 op with latency 0");
        do_issue(2, 11, 1, 0, 1'b0, 0, "R6 reader no stall");
        do_issue(15, 1, 2, 12, 1'b1, 0, "R1 default op");
        do_issue(2, 12, 1, 0, 1'b0, 0, "R1 default latency 1");

        // R7: ratio write dropped while busy
        do_issue(1, 1, 2, 13, 1'b1, 0, "R7 make busy");
        set_ratio(3);
        chk(ratio_cur == 2'd0, "R7 write dropped while busy", ratio_cur, 0);
        chk(fab_ce == 1'b1, "R7 still 1:1 enable", fab_ce, 1);
        step(3);
        chk(busy == 1'b0, "R8 idle before ratio change", busy, 0);

        // R2: ratio 1:4 accepted; enable pattern 1,0,0,0,...
        set_ratio(3);
        chk(ratio_cur == 2'd3, "R7 write accepted when idle", ratio_cur, 3);
        for (int k = 0; k < 8; k++) begin
            chk(fab_ce == ((k % 4) == 0), "R2 enable pattern 1:4", fab_ce, int'((k % 4) == 0));
            step(1);
        end
        // R4 at 1:4: latency 4 spans 16 processor cycles
        do_issue(1, 1, 2, 14, 1'b1, 0, "R3 issue on enable cycle");
        do_issue(2, 14, 1, 0, 1'b0, 15, "R4 reader at 1:4");
        // R3: request between enables waits for the next one
        do_issue(2, 1, 2, 0, 1'b0, 3, "R3 wait for fabric enable");

        // R2: ratio 1:2
        set_ratio(1);
        chk(ratio_cur == 2'd1, "R2 ratio 1:2 loaded", ratio_cur, 1);
        for (int k = 0; k < 4; k++) begin
            chk(fab_ce == ((k % 2) == 0), "R2 enable pattern 1:2", fab_ce, int'((k % 2) == 0));
            step(1);
        end

        // R7: ratio write in the same cycle as an issue is dropped
        req_valid = 1'b1; req_op = 4'd2; req_src_a = 5'd1; req_src_b = 5'd2;
        req_dst = 5'd0; req_dst_en = 1'b0;
        ratio_wr = 1'b1; ratio_code = 2'd2;
        exp_cyc.push_back(cyc);
        exp_tag.push_back("R7 issue alongside ratio write");
        step(1);
        req_valid = 1'b0; ratio_wr = 1'b0;
        chk(ratio_cur == 2'd1, "R7 write dropped on issue cycle", ratio_cur, 1);
        chk(fab_ce == 1'b0, "R2 1:2 phase kept", fab_ce, 0);

        step(4);
        chk(exp_cyc.size() == 0, "R3 all expected issues seen", exp_cyc.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule